// File: doc/BRIEF.md
# Function-Coded Integer ALU

This block is a purely combinational 32-bit arithmetic and logic unit for a single-cycle processor datapath. The operation is not chosen from an opcode list. It is chosen by a 5-bit function code made of four independent fields: a subtract bit, a 2-bit Boolean/shift selector, a shift-unit bit and an arithmetic-unit bit. Any legal code settles to a 32-bit result and four flags (zero, negative, overflow, carry) within the same cycle.

The function code is packed as `{sub, sel[1:0], shu, math}`, so bit 4 is sub, bits 3:2 are sel, bit 1 is shu and bit 0 is math. Four engines run side by side: an adder/subtractor, a bidirectional barrel shifter, a Boolean unit and a set-less-than stage that reads the adder flags. The `math` and `shu` bits pick which engine drives the result. The block holds no state and has no handshake. Its operands are plain inputs, so there is no back-pressure to manage: the result follows the inputs combinationally.

Top module: `alu_fn5`

## Requirements
- R1: Code 5'b00001 (math=1, shu=0, sub=0) gives result = A + B modulo 2^32.
- R2: Code 5'b10001 (math=1, shu=0, sub=1) gives result = A - B modulo 2^32.
- R3: Code 5'b10011 (math=1, shu=1, sub=1, sel[0]=0) gives 32'd1 when A < B as two's-complement signed values, else 32'd0. The result is taken as negative XOR overflow of A - B.
- R4: Code 5'b10111 (math=1, shu=1, sub=1, sel[0]=1) gives 32'd1 when A < B unsigned, else 32'd0. The result is taken as the inverse of the carry out of A + ~B + 1.
- R5: With math=0 and shu=1, the value B is shifted by A[4:0], and bits 31:5 of A have no effect. sel=00 is a logical left shift, sel=10 is a logical right shift and sel=11 is an arithmetic right shift. Codes: 5'b00010, 5'b01010, 5'b01110.
- R6: With math=0 and shu=0, sel selects the Boolean operation: 00 gives AND (5'b00000), 01 gives OR (5'b00100), 10 gives XOR (5'b01000) and 11 gives NOR (5'b01100).
- R7: The zero flag is 1 exactly when the 32-bit result is zero, for every code.
- R8: The negative flag is bit 31 of the adder output. The overflow flag is 1 when the signed sum (sub=0) or the signed difference (sub=1) of A and B does not fit in 32 bits.
- R9: The carry flag is the adder carry out. For sub=0 it is 1 when A + B >= 2^32. For sub=1 it is 1 when A >= B unsigned, meaning no borrow.
- R10: The negative, overflow and carry flags follow the adder for the current A, B and sub bit, even when the shifter or Boolean unit drives the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_i | input | 5 | Function code {sub, sel[1:0], shu, math} |
| a_i | input | 32 | Operand A; its low 5 bits are the shift amount |
| b_i | input | 32 | Operand B; the value that gets shifted |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | Result equals zero |
| neg_o | output | 1 | Adder output bit 31 |
| ovf_o | output | 1 | Adder signed overflow |
| carry_o | output | 1 | Adder carry out |

## Verification
The block holds no state, so any internal fault appears on the result or flag ports as soon as the inputs settle, within the same evaluation. A wrong carry or overflow derivation shows in two places: directly on the flag pins, and indirectly as a wrong bit 0 of the set-less-than result at the signed and unsigned wrap points (0x7FFFFFFF, 0x80000000, 0xFFFFFFFF). A shifter wiring fault shows only at particular shift distances and directions. For that reason every code is exercised against an independent model on corner pairs and on random operands whose upper A bits are set.

// File: rtl/alu_fn5_pkg.sv
package alu_fn5_pkg;
  localparam int unsigned FN_W = 5;

  typedef struct packed {
    logic       sub;
    logic [1:0] sel;
    logic       shu;
    logic       math;
  } alu_fn_t;

  localparam logic [1:0] SEL_AND = 2'b00;
  localparam logic [1:0] SEL_OR  = 2'b01;
  localparam logic [1:0] SEL_XOR = 2'b10;
  localparam logic [1:0] SEL_NOR = 2'b11;
endpackage

// File: rtl/alu_fn5_addsub.sv
module alu_fn5_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             neg_o,
  output logic             ovf_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    wide    = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
    sum_o   = wide[WIDTH-1:0];
    carry_o = wide[WIDTH];
    neg_o   = sum_o[WIDTH-1];
    ovf_o   = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);
  end

  // R9: with no carry out, an addition cannot have wrapped below A
  always_comb begin
    if (!sub_i && !carry_o)
      p_add_nowrap_r9: assert (sum_o >= a_i) else $error("add wrapped without carry");
  end

  // R8: an overflowing add of two operands of the same sign flips the sign
  always_comb begin
    if (!sub_i && ovf_o)
      p_ovf_sign_r8: assert (a_i[WIDTH-1] == b_i[WIDTH-1]) else $error("overflow on mixed signs");
  end
endmodule

// File: rtl/alu_fn5_shift.sv
module alu_fn5_shift #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [SHW-1:0]   amt_i,
  input  logic             left_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] out_o
);
  logic [WIDTH-1:0] stage [SHW+1];
  logic [WIDTH-1:0] flipped_in;
  logic [WIDTH-1:0] flipped_out;
  logic             fill;

  assign fill = arith_i & ~left_i & val_i[WIDTH-1];

  // A left shift is a right shift of the bit-reversed word
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign flipped_in[i]  = left_i ? val_i[WIDTH-1-i] : val_i[i];
    assign flipped_out[i] = left_i ? stage[SHW][WIDTH-1-i] : stage[SHW][i];
  end

  assign stage[0] = flipped_in;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int unsigned D = 1 << s;
    assign stage[s+1] = amt_i[s] ? {{D{fill}}, stage[s][WIDTH-1:D]} : stage[s];
  end

  assign out_o = flipped_out;

  // R5: a zero shift distance passes the value through
  always_comb begin
    if (amt_i == '0)
      p_shamt_zero_r5: assert (out_o == val_i) else $error("zero shift altered value");
  end

  // R5: a nonzero left shift always brings a zero into bit 0
  always_comb begin
    if (left_i && amt_i != '0)
      p_left_fill_r5: assert (out_o[0] == 1'b0) else $error("left shift filled with one");
  end
endmodule

// File: rtl/alu_fn5_logic.sv
module alu_fn5_logic
  import alu_fn5_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] out_o
);
  always_comb begin
    unique case (sel_i)
      SEL_AND: out_o = a_i & b_i;
      SEL_OR:  out_o = a_i | b_i;
      SEL_XOR: out_o = a_i ^ b_i;
      default: out_o = ~(a_i | b_i);
    endcase
  end

  // R6: an AND result sets no bit that A lacks
  always_comb begin
    if (sel_i == SEL_AND)
      p_and_subset_r6: assert ((out_o & ~a_i) == '0) else $error("AND set a bit outside A");
  end
endmodule

// File: rtl/alu_fn5.sv
module alu_fn5
  import alu_fn5_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW = $clog2(WIDTH)
) (
  input  logic [FN_W-1:0]  fn_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             ovf_o,
  output logic             carry_o
);
  alu_fn_t          fn;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] boolean_res;
  logic             less;

  assign fn = alu_fn_t'(fn_i);

  alu_fn5_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(fn.sub),
    .sum_o(sum), .neg_o(neg_o), .ovf_o(ovf_o), .carry_o(carry_o)
  );

  alu_fn5_shift #(.WIDTH(WIDTH)) u_shift (
    .val_i(b_i), .amt_i(a_i[SHW-1:0]),
    .left_i(~fn.sel[1]), .arith_i(fn.sel[0]),
    .out_o(shifted)
  );

  alu_fn5_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i(a_i), .b_i(b_i), .sel_i(fn.sel), .out_o(boolean_res)
  );

  // Comparisons reuse the adder's flags instead of a separate comparator
  assign less = fn.sel[0] ? ~carry_o : (neg_o ^ ovf_o);

  always_comb begin
    if (fn.math) result_o = fn.shu ? {{(WIDTH-1){1'b0}}, less} : sum;
    else         result_o = fn.shu ? shifted : boolean_res;
  end

  assign zero_o = (result_o == '0);

  // R3: signed set-less-than agrees with a signed comparison of the ports
  always_comb begin
    if (fn.math && fn.shu && fn.sub && !fn.sel[0])
      p_slt_signed_r3: assert (result_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
        else $error("signed compare mismatch");
  end

  // R4: unsigned set-less-than agrees with an unsigned comparison of the ports
  always_comb begin
    if (fn.math && fn.shu && fn.sub && fn.sel[0])
      p_slt_unsigned_r4: assert (result_o == {{(WIDTH-1){1'b0}}, (a_i < b_i)})
        else $error("unsigned compare mismatch");
  end
endmodule

// File: tb/tb_alu_fn5.sv
module tb_alu_fn5;
  logic        clk = 1'b0;
  logic [4:0]  fn;
  logic [31:0] a, b, res;
  logic        z, n, v, c;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  alu_fn5 dut (
    .fn_i(fn), .a_i(a), .b_i(b), .result_o(res),
    .zero_o(z), .neg_o(n), .ovf_o(v), .carry_o(c)
  );

  localparam int NV = 12;
  localparam logic [4:0]  T_FN [NV] = '{5'b00001, 5'b10001, 5'b10011, 5'b10111,
    5'b00010, 5'b01010, 5'b01110, 5'b00000, 5'b00100, 5'b01000, 5'b01100, 5'b00010};
  localparam logic [31:0] T_A [NV] = '{32'd5, 32'd5, 32'hFFFFFFFF, 32'hFFFFFFFF,
    32'd4, 32'd4, 32'd4, 32'hF0F0F0F0, 32'hF0F0F0F0, 32'hF0F0F0F0, 32'hF0F0F0F0, 32'h21};
  localparam logic [31:0] T_B [NV] = '{32'd7, 32'd7, 32'd1, 32'd1,
    32'd3, 32'h80000000, 32'h80000000, 32'hFF00FF00, 32'hFF00FF00, 32'hFF00FF00,
    32'hFF00FF00, 32'd1};
  localparam logic [31:0] T_R [NV] = '{32'd12, 32'hFFFFFFFE, 32'd1, 32'd0,
    32'h30, 32'h08000000, 32'hF8000000, 32'hF000F000, 32'hFFF0FFF0, 32'h0FF00FF0,
    32'h000F000F, 32'd2};
  localparam logic [4:0] CODES [11] = '{5'b00001, 5'b10001, 5'b10011, 5'b10111,
    5'b00010, 5'b01010, 5'b01110, 5'b00000, 5'b00100, 5'b01000, 5'b01100};
  localparam logic [31:0] CORNER [6] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
    32'hFFFFFFFF, 32'h80000001};

  function automatic string tag_of(input logic [4:0] f);
    case (f)
      5'b00001: return "R1";
      5'b10001: return "R2";
      5'b10011: return "R3";
      5'b10111: return "R4";
      5'b00010, 5'b01010, 5'b01110: return "R5";
      default:  return "R6";
    endcase
  endfunction

  function automatic logic [31:0] ref_res(input logic [4:0] f, input logic [31:0] x, input logic [31:0] y);
    case (f)
      5'b00001: return x + y;
      5'b10001: return x - y;
      5'b10011: return {31'd0, $signed(x) < $signed(y)};
      5'b10111: return {31'd0, x < y};
      5'b00010: return y << x[4:0];
      5'b01010: return y >> x[4:0];
      5'b01110: return $signed(y) >>> x[4:0];
      5'b00000: return x & y;
      5'b00100: return x | y;
      5'b01000: return x ^ y;
      default:  return ~(x | y);
    endcase
  endfunction

  // Expected {neg, ovf, carry} from wide integer arithmetic
  function automatic logic [2:0] ref_flags(input logic sub, input logic [31:0] x, input logic [31:0] y);
    longint sx, sy, sr;
    longint unsigned ux, uy;
    logic [31:0] r;
    logic ov, cy;
    sx = longint'($signed(x)); sy = longint'($signed(y));
    ux = {32'd0, x};           uy = {32'd0, y};
    sr = sub ? sx - sy : sx + sy;
    ov = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    cy = sub ? (ux >= uy) : ((ux + uy) > 64'd4294967295);
    r  = sub ? x - y : x + y;
    return {r[31], ov, cy};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic apply(input logic [4:0] f, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    fn = f; a = x; b = y;
    #1;
  endtask

  task automatic full_check(input logic [4:0] f, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] er;
    apply(f, x, y);
    er = ref_res(f, x, y);
    check(tag_of(f), res, er, "result");
    check("R7", {31'd0, z}, {31'd0, er == 32'd0}, "zero flag");
    check("R10", {29'd0, n, v, c}, {29'd0, ref_flags(f[4], x, y)}, "adder flags");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    fn = '0; a = '0; b = '0;
    // Idle inputs: AND of zeros gives zero result with zero flag set (R6, R7)
    apply(5'b00000, 32'd0, 32'd0);
    check("R6", res, 32'd0, "idle result");
    check("R7", {31'd0, z}, 32'd1, "idle zero flag");

    for (int i = 0; i < NV; i++) begin
      apply(T_FN[i], T_A[i], T_B[i]);
      check(tag_of(T_FN[i]), res, T_R[i], $sformatf("vector %0d", i));
    end

    // R8: signed overflow on add; R9: no carry
    apply(5'b00001, 32'h7FFFFFFF, 32'h1);
    check("R8", {31'd0, v}, 32'd1, "add overflow");
    check("R8", {31'd0, n}, 32'd1, "add negative");
    check("R9", {31'd0, c}, 32'd0, "add carry");
    // R9: carry out on unsigned wrap; R7 zero result
    apply(5'b00001, 32'hFFFFFFFF, 32'h1);
    check("R9", {31'd0, c}, 32'd1, "wrap carry");
    check("R7", {31'd0, z}, 32'd1, "wrap zero");
    // R2/R9: equal subtract, no borrow
    apply(5'b10001, 32'h1234, 32'h1234);
    check("R9", {31'd0, c}, 32'd1, "sub no borrow");
    check("R7", {31'd0, z}, 32'd1, "sub equal zero");
    // R3: most negative vs most positive
    apply(5'b10011, 32'h80000000, 32'h7FFFFFFF);
    check("R3", res, 32'd1, "slt wrap");
    // R4: same operands unsigned
    apply(5'b10111, 32'h80000000, 32'h7FFFFFFF);
    check("R4", res, 32'd0, "sltu wrap");
    // R5: arithmetic shift by 31, upper A bits set
    apply(5'b01110, 32'hFFFFFFFF, 32'h80000000);
    check("R5", res, 32'hFFFFFFFF, "sra 31");
    // R10: flags live during a Boolean operation
    apply(5'b01000, 32'h7FFFFFFF, 32'h7FFFFFFF);
    check("R10", {29'd0, n, v, c}, {29'd0, 3'b110}, "flags under xor");

    foreach (CODES[k])
      foreach (CORNER[i])
        foreach (CORNER[j])
          full_check(CODES[k], CORNER[i], CORNER[j]);

    for (int r = 0; r < 60; r++)
      foreach (CODES[k])
        full_check(CODES[k], $urandom(), $urandom());

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule